// File: doc/BRIEF.md
# BCD Real-Time Clock with Frozen Host View

This block keeps calendar time in packed BCD for a host that reaches every register at its own address over a single-cycle synchronous bus. A set of internal counters (seconds, minutes, hours, day of week, day of month, month, two-digit year and century) steps forward once for each pulse on `tick`. A second, host-visible copy of those eight fields is reloaded from the counters on each tick, so the host always reads a coherent snapshot.

The host freezes the visible copy with an update-inhibit control bit. The counters keep running, so no time is lost while the host reads a consistent set of fields. To set the time, the host raises the inhibit bit and writes the fields it wants to change. Clearing the bit loads exactly those fields into the counters. An alarm compares seconds, minutes, hours and day of month against the freshly refreshed time, sets a flag that a read clears, and drives an active-low interrupt when that is enabled.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time fields read 20 (century), 00 (year), 01 (month), 01 (day of week), 01 (day of month), 00:00:00. Control (address 14) reads 0x03, the enables register (address 12) and the flags register (address 13) read 0x00, alarm seconds (address 8) reads 0x00, and `irq_n` is 1.
- R2: Each `tick` with the run bit set advances the counters one second in BCD. Seconds go from 59 to 00 and carry into minutes, minutes go from 59 to 00 and carry into hours, and hours go from 23 to 00 and carry into the day (including the 09 to 10 digit carry).
- R3: On a day carry, day of week goes from 07 to 01. Day of month goes to 01 after the last day of the month: 31, 30 for months 04/06/09/11, 28 for month 02, or 29 for month 02 when the year is divisible by four. Month 12 goes to 01 with a year carry, and year 99 goes to 00 with a century increment.
- R4: The visible fields sit at addresses 0 to 7: seconds, minutes, hours, day of month, day of week, month, year, century. On a tick while control bit 3 is 0, all eight take the new counter values, which can be read from the next cycle.
- R5: While control bit 3 is 1, ticks leave the visible fields unchanged, but the counters keep advancing. The first tick after bit 3 is cleared shows the fully elapsed time.
- R6: If a control write sets bit 3 in the same cycle as a tick, that tick's refresh still completes. The visible fields freeze from the next tick on.
- R7: A write to a time field while bit 3 is 1 reads back at once. When a control write clears bit 3, only the fields written during the freeze are loaded into the counters, and the other fields keep their running values.
- R8: Writes to addresses 0 to 7 while bit 3 is 0 are ignored by both the visible fields and the counters.
- R9: Control bit 0 is an active-low stop (1 = run). While it is 0, ticks do not advance the counters.
- R10: On a refresh, if the new seconds, minutes, hours and day of month equal the alarm registers at addresses 8, 9, 10 and 11, flags bit 0 is set, even when the interrupt is disabled.
- R11: A read of the flags register returns the flag and clears it after that cycle. A new alarm match in the same cycle wins.
- R12: `irq_n` is 0 exactly while flags bit 0 and enables bit 0 are both 1. It returns to 1 after the flags register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, one per second |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (needed for the flag clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions take for granted that every value the host writes into a time field is valid BCD within that field's range. The rollover properties only cover counters that move along the legal sequence. They also assume `reset` is applied before the first tick. The stimulus therefore loads only real calendar dates and times, and sends each tick as an isolated one-cycle pulse. The one exception is the deliberate case where a tick and a control write share a cycle. Bus accesses are driven one at a time, each held for exactly one cycle.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NFIELD = 8;
  localparam int NALARM = 4;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOM  = 3;
  localparam int F_DOW  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  localparam int A_ALM0 = NFIELD;
  localparam int A_ENAB = 12;
  localparam int A_FLAG = 13;
  localparam int A_CTRL = 14;

  localparam int CTL_INH = 3;
  localparam int CTL_RUN = 0;
  localparam logic [7:0] CTL_MASK = 8'h0B;
  localparam logic [7:0] CTL_RST  = 8'h03;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction

  function automatic logic year_leap(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    if (m == 8'h02)
      r = year_leap(y) ? 8'h29 : 8'h28;
    else if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11)
      r = 8'h30;
    else
      r = 8'h31;
    return r;
  endfunction

  function automatic logic [7:0] field_rst(input int i, input logic [7:0] cent);
    logic [7:0] r;
    if (i == F_DOM || i == F_DOW || i == F_MON) r = 8'h01;
    else if (i == F_CENT)                        r = cent;
    else                                         r = 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] cur,
  output logic [NFIELD-1:0][7:0] nxt
);
  logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

  always_comb begin
    c_min  = (cur[F_SEC] == 8'h59);
    c_hour = c_min  && (cur[F_MIN]  == 8'h59);
    c_day  = c_hour && (cur[F_HOUR] == 8'h23);
    c_mon  = c_day  && (cur[F_DOM]  == month_last(cur[F_MON], cur[F_YEAR]));
    c_year = c_mon  && (cur[F_MON]  == 8'h12);
    c_cent = c_year && (cur[F_YEAR] == 8'h99);

    nxt = cur;
    nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(cur[F_SEC]);
    if (c_min)  nxt[F_MIN]  = c_hour ? 8'h00 : bcd_inc(cur[F_MIN]);
    if (c_hour) nxt[F_HOUR] = c_day  ? 8'h00 : bcd_inc(cur[F_HOUR]);
    if (c_day) begin
      nxt[F_DOW] = (cur[F_DOW] == 8'h07) ? 8'h01 : bcd_inc(cur[F_DOW]);
      nxt[F_DOM] = c_mon ? 8'h01 : bcd_inc(cur[F_DOM]);
    end
    if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(cur[F_MON]);
    if (c_year) nxt[F_YEAR] = c_cent ? 8'h00 : bcd_inc(cur[F_YEAR]);
    if (c_cent) nxt[F_CENT] = bcd_inc(cur[F_CENT]);
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import bcd_rtc_pkg::*;
#(
  parameter logic [7:0] CENT_RST = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    run,
  input  logic                    inhibit,
  input  logic                    commit,
  input  logic [NFIELD-1:0]       fld_we,
  input  logic [7:0]              wdata,
  output logic [NFIELD-1:0][7:0]  vis_o,
  output logic [NALARM-1:0][7:0]  now_o,
  output logic                    refresh_o
);
  logic [NFIELD-1:0][7:0] cnt_q, cnt_d, merged, adv;
  logic [NFIELD-1:0][7:0] vis_q, vis_d;
  logic [NFIELD-1:0]      dirty_q, dirty_d;
  logic                   tick_go, refresh;

  rtc_calendar u_cal (.cur(merged), .nxt(adv));

  always_comb begin
    tick_go = tick && run;
    refresh = tick && !inhibit;
    for (int i = 0; i < NFIELD; i++) begin
      merged[i] = (commit && dirty_q[i]) ? vis_q[i] : cnt_q[i];
    end
    cnt_d = tick_go ? adv : merged;
    for (int i = 0; i < NFIELD; i++) begin
      if (refresh)                   vis_d[i] = cnt_d[i];
      else if (inhibit && fld_we[i]) vis_d[i] = wdata;
      else                           vis_d[i] = vis_q[i];
      if (commit)                    dirty_d[i] = 1'b0;
      else if (inhibit && fld_we[i]) dirty_d[i] = 1'b1;
      else                           dirty_d[i] = dirty_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) begin
        cnt_q[i] <= field_rst(i, CENT_RST);
        vis_q[i] <= field_rst(i, CENT_RST);
      end
      dirty_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      vis_q   <= vis_d;
      dirty_q <= dirty_d;
    end
  end

  assign vis_o     = vis_q;
  assign now_o     = cnt_d[NALARM-1:0];
  assign refresh_o = refresh;

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !commit && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00));
  p_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !inhibit) |=> (vis_q == cnt_q));
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && fld_we == '0) |=> $stable(vis_q));
  p_dirty_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (dirty_q == '0));
  p_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && !tick) |=> $stable(vis_q));
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !commit) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NALARM-1:0]      alm_we,
  input  logic [7:0]             wdata,
  input  logic                   refresh,
  input  logic [NALARM-1:0][7:0] now,
  input  logic                   flag_rd,
  output logic [NALARM-1:0][7:0] alm_o,
  output logic                   flag_o
);
  logic [NALARM-1:0][7:0] alm_q, alm_d;
  logic [NALARM-1:0]      hit;
  logic                   flag_q, flag_d;

  for (genvar g = 0; g < NALARM; g++) begin : g_cmp
    assign hit[g] = (alm_q[g] == now[g]);
  end

  always_comb begin
    for (int i = 0; i < NALARM; i++) begin
      alm_d[i] = alm_we[i] ? wdata : alm_q[i];
    end
    if (refresh && (&hit)) flag_d = 1'b1;
    else if (flag_rd)      flag_d = 1'b0;
    else                   flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      alm_q  <= alm_d;
      flag_q <= flag_d;
    end
  end

  assign alm_o  = alm_q;
  assign flag_o = flag_q;

  p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(refresh));
  p_rdclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !refresh) |=> !flag_q);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter logic [7:0] CENT_RST = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_ENAB = ADDR_W'(A_ENAB);
  localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);

  logic [7:0]             ctrl_q, ctrl_d;
  logic                   aie_q, aie_d;
  logic [NFIELD-1:0]      fld_we;
  logic [NALARM-1:0]      alm_we;
  logic                   ctrl_wr, commit, flag_rd, refresh, flag;
  logic [NFIELD-1:0][7:0] vis;
  logic [NALARM-1:0][7:0] now, alm;

  always_comb begin
    for (int i = 0; i < NFIELD; i++)
      fld_we[i] = reg_wr && (reg_addr == ADDR_W'(i));
    for (int j = 0; j < NALARM; j++)
      alm_we[j] = reg_wr && (reg_addr == ADDR_W'(A_ALM0 + j));
    ctrl_wr = reg_wr && (reg_addr == AD_CTRL);
    commit  = ctrl_wr && ctrl_q[CTL_INH] && !reg_wdata[CTL_INH];
    flag_rd = reg_rd && (reg_addr == AD_FLAG);
    ctrl_d  = ctrl_wr ? (reg_wdata & CTL_MASK) : ctrl_q;
    aie_d   = (reg_wr && reg_addr == AD_ENAB) ? reg_wdata[0] : aie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTL_RST;
      aie_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      aie_q  <= aie_d;
    end
  end

  rtc_time_core #(.CENT_RST(CENT_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(ctrl_q[CTL_RUN]), .inhibit(ctrl_q[CTL_INH]), .commit(commit),
    .fld_we(fld_we), .wdata(reg_wdata),
    .vis_o(vis), .now_o(now), .refresh_o(refresh)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .alm_we(alm_we), .wdata(reg_wdata),
    .refresh(refresh), .now(now), .flag_rd(flag_rd),
    .alm_o(alm), .flag_o(flag)
  );

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = vis[i];
    for (int j = 0; j < NALARM; j++)
      if (reg_addr == ADDR_W'(A_ALM0 + j)) reg_rdata = alm[j];
    if (reg_addr == AD_ENAB) reg_rdata = {7'd0, aie_q};
    if (reg_addr == AD_FLAG) reg_rdata = {7'd0, flag};
    if (reg_addr == AD_CTRL) reg_rdata = ctrl_q;
  end

  assign irq_n = ~(flag & aie_q);

  p_irq_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !refresh) |=> irq_n);
endmodule

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
  logic       clk, rst_n, tick, reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  wire  [7:0] reg_rdata;
  wire        irq_n;
  int n_chk = 0, n_fail = 0;

  bcd_rtc u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [63:0] start;
    logic [7:0]  nt;
    logic [63:0] expv;
  } vec_t;

  // byte i of each time word = register address i
  localparam vec_t VT [10] = '{
    '{64'h20240101_01000000, 8'd1, 64'h20240101_01000001},
    '{64'h20240603_15235959, 8'd1, 64'h20240604_16000000},
    '{64'h20240407_30235959, 8'd1, 64'h20240501_01000000},
    '{64'h20230202_28235959, 8'd1, 64'h20230303_01000000},
    '{64'h20240202_28235959, 8'd1, 64'h20240203_29000000},
    '{64'h20991205_31235959, 8'd1, 64'h21000106_01000000},
    '{64'h20240101_01000058, 8'd3, 64'h20240101_01000101},
    '{64'h20240101_01095959, 8'd1, 64'h20240101_01100000},
    '{64'h20240101_31235959, 8'd1, 64'h20240202_01000000},
    '{64'h20240204_29235959, 8'd1, 64'h20240305_01000000}
  };
  localparam logic [63:0] BASE = 64'h20240101_01000000;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic load(input logic [63:0] t);
    wr(4'd14, 8'h0B);
    for (int i = 0; i < 8; i++) wr(4'(i), t[8*i +: 8]);
    wr(4'd14, 8'h03);
  endtask

  task automatic rd_all(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), b);
      t[8*i +: 8] = b;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] t;
    logic [7:0]  b;
    rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_all(t);        chk("R1 time", t, 64'h20000101_01000000);
    rd(4'd14, b);     chk("R1 ctrl", {56'd0, b}, 64'h03);
    rd(4'd12, b);     chk("R1 enables", {56'd0, b}, 64'h00);
    rd(4'd13, b);     chk("R1 flags", {56'd0, b}, 64'h00);
    rd(4'd8, b);      chk("R1 alarm sec", {56'd0, b}, 64'h00);
    chk("R1 irq_n", {63'd0, irq_n}, 64'd1);

    // R2 R3 R4 R7 vector table: load, tick, read back
    for (int v = 0; v < 10; v++) begin
      load(VT[v].start);
      for (int k = 0; k < int'(VT[v].nt); k++) pulse();
      rd_all(t);
      chk($sformatf("R2/R3/R4 vector %0d", v), t, VT[v].expv);
    end

    // R5 freeze while counters keep running
    load(BASE | 64'h10);
    wr(4'd14, 8'h0B);
    repeat (3) pulse();
    rd(4'd0, b);  chk("R5 frozen sec", {56'd0, b}, 64'h10);
    wr(4'd14, 8'h03);
    pulse();
    rd(4'd0, b);  chk("R5 elapsed sec", {56'd0, b}, 64'h14);

    // R6 inhibit set in the same cycle as a tick
    load(BASE | 64'h20);
    @(negedge clk); tick = 1'b1; reg_addr = 4'd14; reg_wdata = 8'h0B; reg_wr = 1'b1;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
    rd(4'd0, b);  chk("R6 refresh completed", {56'd0, b}, 64'h21);
    pulse();
    rd(4'd0, b);  chk("R6 then frozen", {56'd0, b}, 64'h21);
    wr(4'd14, 8'h03);
    pulse();
    rd(4'd0, b);  chk("R6 after release", {56'd0, b}, 64'h23);

    // R7 only written fields are committed
    load(BASE | 64'h30);
    wr(4'd14, 8'h0B);
    wr(4'd1, 8'h42);
    rd(4'd1, b);  chk("R7 immediate readback", {56'd0, b}, 64'h42);
    pulse();
    wr(4'd14, 8'h03);
    pulse();
    rd_all(t);    chk("R7 partial commit", t, BASE | 64'h4232);

    // R8 writes ignored while not inhibited
    load(BASE | 64'h40);
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h33);
    rd(4'd0, b);  chk("R8 ignored sec", {56'd0, b}, 64'h40);
    pulse();
    rd_all(t);    chk("R8 counters untouched", t, BASE | 64'h41);

    // R9 stop bit
    load(BASE | 64'h50);
    wr(4'd14, 8'h02);
    repeat (2) pulse();
    rd(4'd0, b);  chk("R9 stopped", {56'd0, b}, 64'h50);
    wr(4'd14, 8'h03);
    pulse();
    rd(4'd0, b);  chk("R9 resumed", {56'd0, b}, 64'h51);

    // R10 R11 R12 alarm
    load(BASE);
    wr(4'd8, 8'h03); wr(4'd9, 8'h00); wr(4'd10, 8'h00); wr(4'd11, 8'h01);
    wr(4'd12, 8'h01);
    repeat (2) pulse();
    chk("R12 no irq before match", {63'd0, irq_n}, 64'd1);
    rd(4'd13, b); chk("R10 no flag before match", {56'd0, b}, 64'h00);
    pulse();
    chk("R12 irq asserted", {63'd0, irq_n}, 64'd0);
    rd(4'd13, b); chk("R11 flag read returns set", {56'd0, b}, 64'h01);
    chk("R12 irq released", {63'd0, irq_n}, 64'd1);
    rd(4'd13, b); chk("R11 flag cleared", {56'd0, b}, 64'h00);
    wr(4'd12, 8'h00);
    wr(4'd8, 8'h05);
    repeat (2) pulse();
    chk("R12 irq masked", {63'd0, irq_n}, 64'd1);
    rd(4'd13, b); chk("R10 flag set while disabled", {56'd0, b}, 64'h01);

    finish_run();
  end
endmodule